// File: doc/BRIEF.md
# Transmit Fault-Distance Timer

This block times how long a transmitted frame keeps its carrier. A one-cycle transmit-start strobe clears a 10-bit count and opens a counting window. While the window is open, every cycle that carries the 10 MHz enable tick adds one to the count. The window closes when carrier is lost, meaning carrier sense was high on the previous clock and is low on this one. It also closes when the transmission ends without a loss. Software reads the count to estimate how far away a cable fault is, because a reflection or short cuts the carrier off early.

The window is run by a three-state machine. ST_IDLE is the state after reset. ST_COUNT is the open window. ST_HOLD holds a finished result. The transitions are named as follows:
- START_FROM_IDLE goes from ST_IDLE to ST_COUNT on the start strobe.
- RESTART goes from ST_COUNT back to ST_COUNT on a new start strobe.
- CARRIER_LOST goes from ST_COUNT to ST_HOLD on a carrier falling edge.
- TX_DONE goes from ST_COUNT to ST_HOLD on the end-of-transmission pulse.
- REARM goes from ST_HOLD to ST_COUNT on the start strobe.

The count is read out through a 16-bit register port. The count sits in the low 10 bits and the upper bits read as zero. The register is readable only while the controller reports that it is stopped or suspended. Host writes to the register are accepted and have no effect.

Top module: `tdr_fault_timer`

## Requirements
- R1: In ST_COUNT, each cycle with `tick_10m` high and no start, loss or end event adds exactly one to the count.
- R2: Loss of carrier (`carrier_sense` 1 on the previous clock and 0 on this one) in ST_COUNT closes the window. A tick in that same cycle is not counted.
- R3: An `tx_end` pulse in ST_COUNT with no loss closes the window. A tick in that cycle is not counted, and the count is held afterwards.
- R4: The count saturates at 1023. Further ticks leave it at 1023 instead of wrapping to zero.
- R5: A `tx_start` pulse in any state sets the count to 0 on the next clock and enters ST_COUNT. A tick in the start cycle is not counted.
- R6: Reset makes the count 0 and the state ST_IDLE.
- R7: `reg_rdata` is {6'b0, count[9:0]} when `reg_rd` is high and `ctrl_stopped` or `ctrl_suspended` is high. In every other case it is 16'h0000.
- R8: A host write (`reg_wr` with any `reg_wdata`) does not change the count.
- R9: Ticks in ST_IDLE or ST_HOLD do not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_start | input | 1 | One-cycle strobe at the start of a transmission |
| tx_end | input | 1 | One-cycle strobe at the end of a transmission |
| carrier_sense | input | 1 | Carrier present on the medium |
| tick_10m | input | 1 | 10 MHz count-enable tick, one clock wide |
| ctrl_stopped | input | 1 | Controller is in the stopped state |
| ctrl_suspended | input | 1 | Controller is in the suspended state |
| reg_rd | input | 1 | Register read enable |
| reg_wr | input | 1 | Register write strobe (ignored) |
| reg_wdata | input | 16 | Register write data (ignored) |
| reg_rdata | output | 16 | Register read data |

## Verification
Three functions can land in the same cycle as a count tick: loss of carrier, end of transmission and a restart strobe. In each of those cycles the tick must be dropped. The bench holds `tick_10m` high through the cycle where carrier falls, through the cycle where `tx_end` pulses, and through a `tx_start` issued while counting. A behavioural model compares the read value on every clock, and directed checks look for the exact counts 5, 3 and 0.

// File: rtl/tdr_pkg.sv
package tdr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_HOLD  = 2'd2
    } tdr_state_e;

endpackage

// File: rtl/tdr_carrier_edge.sv
module tdr_carrier_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic carrier_sense,
    output logic carrier_lost
);

    logic cs_prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_prev_q <= 1'b0;
        end else begin
            cs_prev_q <= carrier_sense;
        end
    end

    always_comb begin
        carrier_lost = cs_prev_q && !carrier_sense;
    end

    // R2: a detected loss implies carrier was present one clock earlier
    p_loss_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        carrier_lost |-> $fell(carrier_sense));

endmodule

// File: rtl/tdr_window_fsm.sv
module tdr_window_fsm
    import tdr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_start,
    input  logic       tx_end,
    input  logic       carrier_lost,
    input  logic       tick_10m,
    output logic       cnt_clear,
    output logic       cnt_inc,
    output tdr_state_e state
);

    tdr_state_e state_q;
    tdr_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (tx_start) state_d = ST_COUNT;          // START_FROM_IDLE
            end
            ST_COUNT: begin
                if (tx_start)          state_d = ST_COUNT; // RESTART
                else if (carrier_lost) state_d = ST_HOLD;  // CARRIER_LOST
                else if (tx_end)       state_d = ST_HOLD;  // TX_DONE
            end
            ST_HOLD: begin
                if (tx_start) state_d = ST_COUNT;          // REARM
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        cnt_clear = tx_start;
        cnt_inc   = 1'b0;
        unique case (state_q)
            ST_COUNT: cnt_inc = tick_10m && !tx_start && !carrier_lost && !tx_end;
            ST_IDLE,
            ST_HOLD:  cnt_inc = 1'b0;
            default:  cnt_inc = 1'b0;
        endcase
        state = state_q;
    end

    p_stop_on_loss_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && carrier_lost && !tx_start) |=> state_q == ST_HOLD);

    p_stop_on_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && tx_end && !tx_start) |=> state_q == ST_HOLD);

    p_start_opens_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> state_q == ST_COUNT);

endmodule

// File: rtl/tdr_sat_counter.sv
module tdr_sat_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt = cnt_q;

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !clr) |=> cnt_q == CNT_MAX);

    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);

    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt_q == '0);

endmodule

// File: rtl/tdr_read_port.sv
module tdr_read_port #(
    parameter int CNT_W = 10,
    parameter int REG_W = 16
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic             reg_rd,
    input  logic             ctrl_stopped,
    input  logic             ctrl_suspended,
    output logic [REG_W-1:0] reg_rdata
);

    localparam int PAD_W = REG_W - CNT_W;

    logic access_ok;

    always_comb begin
        access_ok = reg_rd && (ctrl_stopped || ctrl_suspended);
        reg_rdata = access_ok ? {{PAD_W{1'b0}}, cnt} : '0;
    end

    always_comb begin
        if (!(ctrl_stopped || ctrl_suspended)) begin
            a_gate_r7: assert (reg_rdata == '0);
        end
    end

endmodule

// File: rtl/tdr_fault_timer.sv
module tdr_fault_timer
    import tdr_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_start,
    input  logic             tx_end,
    input  logic             carrier_sense,
    input  logic             tick_10m,
    input  logic             ctrl_stopped,
    input  logic             ctrl_suspended,
    input  logic             reg_rd,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata
);

    logic             carrier_lost;
    logic             cnt_clear;
    logic             cnt_inc;
    logic [CNT_W-1:0] count;
    tdr_state_e       state;

    tdr_carrier_edge u_edge (
        .clk           (clk),
        .rst_n         (rst_n),
        .carrier_sense (carrier_sense),
        .carrier_lost  (carrier_lost)
    );

    tdr_window_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_start     (tx_start),
        .tx_end       (tx_end),
        .carrier_lost (carrier_lost),
        .tick_10m     (tick_10m),
        .cnt_clear    (cnt_clear),
        .cnt_inc      (cnt_inc),
        .state        (state)
    );

    tdr_sat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clear),
        .inc   (cnt_inc),
        .cnt   (count)
    );

    tdr_read_port #(.CNT_W(CNT_W), .REG_W(REG_W)) u_port (
        .cnt            (count),
        .reg_rd         (reg_rd),
        .ctrl_stopped   (ctrl_stopped),
        .ctrl_suspended (ctrl_suspended),
        .reg_rdata      (reg_rdata)
    );

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_COUNT && !tx_start) |=> $stable(count));

    p_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata != '0 && state != ST_COUNT && !tx_start) |=> $stable(count));

endmodule

// File: tb/tdr_fault_timer_bench.sv
`timescale 1ns/100ps
module tdr_fault_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_start = 1'b0;
    logic        tx_end = 1'b0;
    logic        carrier_sense = 1'b0;
    logic        tick_10m = 1'b0;
    logic        ctrl_stopped = 1'b0;
    logic        ctrl_suspended = 1'b0;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;

    int    n_checks = 0;
    int    n_fail = 0;
    string cur_req = "R6";

    // behavioural reference
    int m_count = 0;
    bit m_busy = 0;
    bit m_prev = 0;

    always #2.5 clk = ~clk;

    tdr_fault_timer u_tdr_fault_timer (
        .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_end(tx_end),
        .carrier_sense(carrier_sense), .tick_10m(tick_10m),
        .ctrl_stopped(ctrl_stopped), .ctrl_suspended(ctrl_suspended),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int model_read();
        if (reg_rd && (ctrl_stopped || ctrl_suspended)) return m_count;
        return 0;
    endfunction

    always @(posedge clk) begin
        bit loss;
        if (!rst_n) begin
            m_count = 0; m_busy = 0; m_prev = 0;
        end else begin
            loss = m_prev && !carrier_sense;
            if (tx_start) begin
                m_count = 0; m_busy = 1;
            end else if (m_busy) begin
                if (loss || tx_end) m_busy = 0;
                else if (tick_10m && m_count < 1023) m_count++;
            end
            m_prev = carrier_sense;
            #1;
            check(cur_req, int'(reg_rdata), model_read());
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic read_check(input string req, input int exp);
        reg_rd = 1'b1; ctrl_stopped = 1'b1;
        #1;
        check(req, int'(reg_rdata), exp);
        reg_rd = 1'b0; ctrl_stopped = 1'b0;
    endtask

    initial begin
        #20000;
        n_checks++; n_fail++;
        $display("FAIL watchdog expired (all requirements)");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        read_check("R6", 0);

        // R1/R2: five ticks, then carrier falls with tick still high
        cur_req = "R1"; carrier_sense = 1'b1; step(1);
        tx_start = 1'b1; tick_10m = 1'b1; step(1);      // tick in start cycle dropped
        tx_start = 1'b0; step(5);
        read_check("R1", 5);
        cur_req = "R2"; carrier_sense = 1'b0; step(1);
        read_check("R2", 5);
        step(4);                                        // R9: ticks in hold ignored
        read_check("R9", 5);
        tick_10m = 1'b0;

        // R7: gating
        reg_rd = 1'b1; #1;
        check("R7", int'(reg_rdata), 0);
        ctrl_suspended = 1'b1; #1;
        check("R7", int'(reg_rdata), 5);
        ctrl_suspended = 1'b0; reg_rd = 1'b0; ctrl_stopped = 1'b1; #1;
        check("R7", int'(reg_rdata), 0);
        ctrl_stopped = 1'b0;

        // R8: writes ignored
        cur_req = "R8"; reg_wr = 1'b1; reg_wdata = 16'hFFFF; step(2);
        reg_wdata = 16'h0000; step(1); reg_wr = 1'b0;
        read_check("R8", 5);

        // R3: end of transmission with tick in same cycle
        cur_req = "R3"; carrier_sense = 1'b1; step(1);
        tx_start = 1'b1; step(1); tx_start = 1'b0;
        tick_10m = 1'b1; step(3);
        tx_end = 1'b1; step(1); tx_end = 1'b0;
        read_check("R3", 3);
        step(3); tick_10m = 1'b0;
        read_check("R9", 3);

        // R5: restart while counting, tick in restart cycle
        cur_req = "R5"; tx_start = 1'b1; step(1); tx_start = 1'b0;
        tick_10m = 1'b1; step(7);
        tx_start = 1'b1; step(1); tx_start = 1'b0; tick_10m = 1'b0;
        read_check("R5", 0);
        tick_10m = 1'b1; step(2); tick_10m = 1'b0;
        read_check("R5", 2);

        // R4: saturation
        cur_req = "R4"; tick_10m = 1'b1; step(1100);
        read_check("R4", 1023);
        tick_10m = 1'b0; step(2); tick_10m = 1'b1; step(1);
        read_check("R4", 1023);
        carrier_sense = 1'b0; step(2); tick_10m = 1'b0;
        read_check("R2", 1023);

        // R6: reset mid-window clears
        cur_req = "R6"; carrier_sense = 1'b1; tx_start = 1'b1; step(1); tx_start = 1'b0;
        tick_10m = 1'b1; step(4); rst_n = 1'b0; step(2); rst_n = 1'b1; step(3);
        tick_10m = 1'b0;
        read_check("R6", 0);

        step(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule